// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block steers the front of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the source register fields of the instruction in decode with the destination field of the instruction in execute. If the execute instruction is a memory read and either decode source names its destination, the decode instruction cannot yet get the loaded value, even with forwarding.

In that case the controller holds the program counter and the fetch/decode register for one cycle, so the same instruction is fetched again. It also zeroes the execute, memory and writeback control bits of the instruction entering execute, which turns that slot into a bubble. Dependences on ALU results do not stall, because forwarding supplies them. Register zero never counts as a dependence.

Branches are predicted not taken, so fetch continues on the fall-through path. When decode resolves a branch as taken, the controller flushes the fetch/decode register to a no-op. A stall wins over a flush in the same cycle, because the decode instruction must be held, not squashed. All outputs are combinational in the current inputs. They stay at zero while reset is asserted.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: When `ex_mem_read`=1 and `ex_rt` (not zero) equals `id_rs`, the outputs are `pc_we`=0, `ifid_we`=0, `ex_ctl_clear`=1 and `ifid_flush`=0 in the same cycle.
- R2: When `ex_mem_read`=1 and `ex_rt` (not zero) equals `id_rt`, the outputs are stall outputs identical to R1.
- R3: When `ex_mem_read`=0, a register match causes no stall: `pc_we`=1, `ifid_we`=1, `ex_ctl_clear`=0.
- R4: When `ex_rt` is register 0, no stall is raised, whatever the decode fields hold.
- R5: With no load-use hazard and `id_branch_taken`=1, the outputs are `ifid_flush`=1, `pc_we`=1, `ifid_we`=1 and `ex_ctl_clear`=0.
- R6: With no hazard and no taken branch, the outputs take their normal values: `pc_we`=1, `ifid_we`=1, `ifid_flush`=0, `ex_ctl_clear`=0.
- R7: When a load-use hazard and a taken branch occur together, the stall outputs of R1 apply and `ifid_flush`=0.
- R8: While `rst`=1, all four outputs are 0, whatever the other inputs are.
- R9: A stall lasts one cycle. Once the bubble makes `ex_mem_read` 0 in the next cycle, the outputs return to their normal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | REG_W (5) | First source register of the decode instruction |
| id_rt | input | REG_W (5) | Second source register of the decode instruction |
| ex_rt | input | REG_W (5) | Load destination register of the execute instruction |
| ex_mem_read | input | 1 | Execute instruction reads memory |
| id_branch_taken | input | 1 | Branch in decode resolved taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_flush | output | 1 | Turn the fetch/decode register into a no-op |
| ex_ctl_clear | output | 1 | Zero the control bits entering execute |

## Verification
Every output is due in the same cycle as the inputs that cause it, since no register lies between the inputs and the outputs. The bench changes inputs on the falling edge and samples the outputs a quarter period later, so the settled value is read before the next rising edge. The one-cycle stall of R9 is checked over two consecutive cycles: the hazard first, then the bubble inputs on the following falling edge. Each of the two cycles is sampled the same way.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_W = 5;

    // front-end steering bundle
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ifid_flush;
        logic ex_ctl_clear;
    } hzd_ctl_t;

    localparam hzd_ctl_t CTL_IDLE   = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_flush: 1'b0, ex_ctl_clear: 1'b0};
    localparam hzd_ctl_t CTL_RUN    = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b0, ex_ctl_clear: 1'b0};
    localparam hzd_ctl_t CTL_STALL  = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_flush: 1'b0, ex_ctl_clear: 1'b1};
    localparam hzd_ctl_t CTL_SQUASH = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b1, ex_ctl_clear: 1'b0};

    function automatic logic reg_is_live(input logic [REG_W-1:0] r);
        return (r != '0);
    endfunction

endpackage

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] id_srcs,
    input  logic [REG_W-1:0]         ex_dst,
    input  logic                     ex_mem_read,
    output logic                     hazard
);
    import hzd_pkg::*;

    logic [NUM_SRC-1:0] src_hit;

    // one comparator per decode source operand
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = (id_srcs[g*REG_W +: REG_W] == ex_dst);
    end

    assign hazard = ex_mem_read && reg_is_live(ex_dst) && (|src_hit);

endmodule

// File: rtl/hzd_branch_flush.sv
module hzd_branch_flush (
    input  logic branch_taken,
    input  logic stall,
    output logic flush
);
    // a held decode instruction is never squashed
    assign flush = branch_taken && !stall;
endmodule

// File: rtl/hzd_ctl_arbiter.sv
module hzd_ctl_arbiter (
    input  logic              rst,
    input  logic              stall,
    input  logic              flush,
    output hzd_pkg::hzd_ctl_t ctl
);
    import hzd_pkg::*;

    always_comb begin
        if (rst)        ctl = CTL_IDLE;
        else if (stall) ctl = CTL_STALL;
        else if (flush) ctl = CTL_SQUASH;
        else            ctl = CTL_RUN;
    end
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl #(
    parameter int REG_W = hzd_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] ex_rt,
    input  logic             ex_mem_read,
    input  logic             id_branch_taken,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             ifid_flush,
    output logic             ex_ctl_clear
);
    import hzd_pkg::*;

    localparam int NUM_SRC = 2;

    logic              lu_hazard;
    logic              br_flush;
    hzd_ctl_t          ctl;

    hzd_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_detect (
        .id_srcs     ({id_rt, id_rs}),
        .ex_dst      (ex_rt),
        .ex_mem_read (ex_mem_read),
        .hazard      (lu_hazard)
    );

    hzd_branch_flush u_flush (
        .branch_taken (id_branch_taken),
        .stall        (lu_hazard),
        .flush        (br_flush)
    );

    hzd_ctl_arbiter u_arb (
        .rst   (rst),
        .stall (lu_hazard),
        .flush (br_flush),
        .ctl   (ctl)
    );

    assign pc_we        = ctl.pc_we;
    assign ifid_we      = ctl.ifid_we;
    assign ifid_flush   = ctl.ifid_flush;
    assign ex_ctl_clear = ctl.ex_ctl_clear;

    AST_HAZARD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        lu_hazard |-> (!pc_we && !ifid_we && ex_ctl_clear)); // R1
    AST_HAZARD_NO_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (lu_hazard && id_branch_taken) |-> !ifid_flush); // R7
    AST_ALU_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !ex_mem_read |-> (pc_we && ifid_we && !ex_ctl_clear)); // R3
    AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (rst)
        (ex_rt == '0) |-> !ex_ctl_clear); // R4
    AST_TAKEN_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (id_branch_taken && !ex_ctl_clear) |-> ifid_flush); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !(pc_we || ifid_we || ifid_flush || ex_ctl_clear)); // R8

endmodule

// File: tb/hzd_stall_ctrl_test.sv
module hzd_stall_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] id_rs = '0, id_rt = '0, ex_rt = '0;
    logic       ex_mem_read = 1'b0, id_branch_taken = 1'b0;
    logic       pc_we, ifid_we, ifid_flush, ex_ctl_clear;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    hzd_stall_ctrl uut (
        .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt), .ex_rt(ex_rt),
        .ex_mem_read(ex_mem_read), .id_branch_taken(id_branch_taken),
        .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
        .ex_ctl_clear(ex_ctl_clear)
    );

    // expected nibble: {pc_we, ifid_we, ifid_flush, ex_ctl_clear}
    localparam logic [3:0] E_RUN = 4'b1100, E_STALL = 4'b0001,
                           E_SQ  = 4'b1110, E_OFF   = 4'b0000;

    // {req[3:0], rs, rt, ex_rt, mem_read, taken, expected[3:0]}
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {4'd1, 5'd3,  5'd4,  5'd3,  1'b1, 1'b0, E_STALL}, // R1
        {4'd1, 5'd31, 5'd30, 5'd31, 1'b1, 1'b0, E_STALL}, // R1
        {4'd2, 5'd7,  5'd9,  5'd9,  1'b1, 1'b0, E_STALL}, // R2
        {4'd3, 5'd5,  5'd5,  5'd5,  1'b0, 1'b0, E_RUN},   // R3
        {4'd4, 5'd0,  5'd0,  5'd0,  1'b1, 1'b0, E_RUN},   // R4
        {4'd5, 5'd1,  5'd2,  5'd6,  1'b0, 1'b1, E_SQ},    // R5
        {4'd5, 5'd1,  5'd2,  5'd6,  1'b1, 1'b1, E_SQ},    // R5
        {4'd6, 5'd1,  5'd2,  5'd6,  1'b1, 1'b0, E_RUN},   // R6
        {4'd7, 5'd8,  5'd2,  5'd8,  1'b1, 1'b1, E_STALL}  // R7
    };

    task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] xr, input logic mr, input logic bt);
        @(negedge clk);
        id_rs = rs; id_rt = rt; ex_rt = xr; ex_mem_read = mr; id_branch_taken = bt;
        #5;
    endtask

    task automatic check(input int req, input logic [3:0] exp);
        logic [3:0] got;
        got = {pc_we, ifid_we, ifid_flush, ex_ctl_clear};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d: outputs=%b expected=%b", req, got, exp);
        end
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog: run hung, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: reset holds everything low, even with a hazard and a taken branch present
        drive(5'd3, 5'd3, 5'd3, 1'b1, 1'b1);
        check(8, E_OFF);
        drive(5'd1, 5'd2, 5'd4, 1'b0, 1'b0);
        check(8, E_OFF);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][20:16], VEC[i][15:11], VEC[i][10:6], VEC[i][5], VEC[i][4]);
            check(int'(VEC[i][24:21]), VEC[i][3:0]);
        end

        // R9: stall one cycle, then the bubble in execute releases it
        drive(5'd12, 5'd13, 5'd13, 1'b1, 1'b0);
        check(9, E_STALL);
        drive(5'd12, 5'd13, 5'd0, 1'b0, 1'b0);
        check(9, E_RUN);
        // R9 with a branch held behind the stall: released cycle flushes
        drive(5'd4, 5'd6, 5'd4, 1'b1, 1'b1);
        check(9, E_STALL);
        drive(5'd4, 5'd6, 5'd0, 1'b0, 1'b1);
        check(9, E_SQ);

        // R2 corner: rs is register 0, rt matches a live load
        drive(5'd0, 5'd17, 5'd17, 1'b1, 1'b0);
        check(2, E_STALL);

        // R8: reset again mid-run
        @(negedge clk); rst = 1'b1;
        drive(5'd9, 5'd9, 5'd9, 1'b1, 1'b0);
        check(8, E_OFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule